// File: doc/BRIEF.md
# Word-to-Narrow-Bus Access Bridge

This block connects a requester that thinks in full words to a memory whose data path is narrower. The requester places an address, a direction flag, an access size and (for a store) the write data on its port, then raises a request strobe for one cycle. The bridge latches all of it and works through the access one memory beat at a time. A full-word access is split into W/B beats at consecutive memory addresses. A byte access (one bus width) takes a single beat. The bridge waits for an acknowledge on every beat before it presents the next one.

The placement of the word's bytes across the consecutive addresses follows a byte-order input that is sampled with the request. Little-endian puts the least significant byte at the lowest address. Big-endian puts the most significant byte there. For a load, the returned pieces are steered into the matching lanes of a read-data register. When the last beat has been acknowledged, the bridge raises a one-cycle completion pulse. It ignores further request strobes until it is idle again.

Top module: `width_bridge`

## Requirements
- R1: While reset is applied and after it is released, `done` and `mem_req` are low and `rdata` is all zeros.
- R2: A request strobe seen at a clock edge while the bridge is idle is accepted, and the first beat is presented from the next cycle. A beat keeps `mem_req` high, with `mem_addr`, `mem_write` and `mem_wdata` unchanged, until the edge at which `mem_ack` is high.
- R3: A full-word access (`req_size`=1) issues exactly W/B beats at addresses `req_addr`, `req_addr`+1, and so on, with one beat retired per acknowledge.
- R4: With `cfg_big_endian`=0, beat k of a full-word access carries word bits [k*B+B-1 : k*B]. With W=16 and B=8, a store of 0xABCD at address 0 leaves 0xCD at 0 and 0xAB at 1.
- R5: With `cfg_big_endian`=1, beat k carries word bits [(W/B-1-k)*B+B-1 : (W/B-1-k)*B]. The same store leaves 0xAB at 0 and 0xCD at 1.
- R6: A byte access (`req_size`=0) issues one beat at `req_addr`. A store writes `req_wdata`[B-1:0]. A load returns the byte in `rdata`[B-1:0] with the upper bits zero. Byte order has no effect on a byte access.
- R7: A full-word load returns the assembled word in `rdata` by the completion pulse, in the byte order of R4/R5. `rdata` then holds its value until the next request is accepted.
- R8: `done` is high for exactly one cycle, the cycle after the edge at which the final beat is acknowledged, and `mem_req` is low in that cycle.
- R9: Request strobes that arrive from the accepting edge up to and including the completion cycle are ignored: they start no beat and alter no memory.
- R10: Direction, size, byte order, address and write data are sampled at the accepting edge. Changing those inputs during the transfer does not change the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_endian | input | 1 | Byte order: 1 puts the most significant byte at the lowest address |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 1 | 1 = full word, 0 = single byte |
| req_addr | input | AW | Byte address of the access |
| req_wdata | input | W | Store data |
| rdata | output | W | Load result register |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Beat valid toward memory |
| mem_write | output | 1 | Beat direction |
| mem_addr | output | AW | Beat byte address |
| mem_wdata | output | B | Beat store data |
| mem_ack | input | 1 | Beat acknowledge from memory |
| mem_rdata | input | B | Beat load data from memory |

## Verification
The bench builds the bridge with W=16, B=8 and AW=16. Two beats per word is the smallest case that still has a first and a last beat that differ, so the lane reversal between the two byte orders and the address step between beats are both exercised. A bench memory with random per-beat acknowledge delay holds beats for several cycles. Request strobes, byte-order flips and size changes are injected into the middle of a transfer to check that they are ignored and that the access uses its sampled attributes.

// File: rtl/wb_pkg.sv
package wb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } wb_state_e;
endpackage

// File: rtl/wb_rst_sync.sv
module wb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wb_sequencer.sv
module wb_sequencer #(
  parameter int BEATS = 2,
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          full_q,
  input  logic          mem_ack,
  output logic          accept,
  output logic          ack_beat,
  output logic [CW-1:0] beat,
  output logic          mem_req,
  output logic          done
);
  import wb_pkg::*;

  localparam logic [CW-1:0] LAST_BEAT = CW'(BEATS - 1);

  wb_state_e     state_q, state_n;
  logic [CW-1:0] beat_q, beat_n;
  logic          last;

  // A byte access ends after its first beat; a word access after the last lane.
  assign last     = !full_q || (beat_q == LAST_BEAT);
  assign accept   = (state_q == ST_IDLE) && req_valid;
  assign ack_beat = (state_q == ST_XFER) && mem_ack;

  always_comb begin
    state_n = state_q;
    beat_n  = beat_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_n = ST_XFER;
          beat_n  = '0;
        end
      end
      ST_XFER: begin
        if (mem_ack) begin
          if (last) state_n = ST_DONE;
          else      beat_n  = beat_q + CW'(1);
        end
      end
      ST_DONE: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_n;
      beat_q  <= beat_n;
    end
  end

  assign beat    = beat_q;
  assign mem_req = (state_q == ST_XFER);
  assign done    = (state_q == ST_DONE);
endmodule

// File: rtl/wb_request_reg.sv
module wb_request_reg #(
  parameter int AW = 16,
  parameter int W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic          req_write,
  input  logic          req_size,
  input  logic          cfg_big_endian,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  output logic          write_q,
  output logic          full_q,
  output logic          big_q,
  output logic [AW-1:0] addr_q,
  output logic [W-1:0]  wdata_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_q <= 1'b0;
      full_q  <= 1'b0;
      big_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      write_q <= req_write;
      full_q  <= req_size;
      big_q   <= cfg_big_endian;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end
endmodule

// File: rtl/wb_lane_mux.sv
module wb_lane_mux #(
  parameter int AW = 16,
  parameter int W  = 16,
  parameter int B  = 8,
  localparam int BEATS = W / B,
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic [CW-1:0] beat,
  input  logic          full_q,
  input  logic          big_q,
  input  logic [AW-1:0] addr_q,
  input  logic [W-1:0]  wdata_q,
  output logic [CW-1:0] lane,
  output logic [AW-1:0] mem_addr,
  output logic [B-1:0]  mem_wdata
);
  logic [B-1:0] lanes [BEATS];

  for (genvar g = 0; g < BEATS; g++) begin : g_split
    assign lanes[g] = wdata_q[g*B +: B];
  end

  // Byte access always uses lane 0; word access walks lanes up or down.
  always_comb begin
    if (!full_q)    lane = '0;
    else if (big_q) lane = CW'(BEATS - 1) - beat;
    else            lane = beat;
  end

  assign mem_addr  = addr_q + AW'(beat);
  assign mem_wdata = lanes[lane];
endmodule

// File: rtl/wb_read_assembler.sv
module wb_read_assembler #(
  parameter int W = 16,
  parameter int B = 8,
  localparam int BEATS = W / B,
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          capture,
  input  logic [CW-1:0] lane,
  input  logic [B-1:0]  mem_rdata,
  output logic [W-1:0]  rdata
);
  for (genvar g = 0; g < BEATS; g++) begin : g_lane
    logic [B-1:0] part_q, part_n;
    logic         part_en;

    assign part_en = clear || (capture && (lane == CW'(g)));

    always_comb begin
      part_n = part_q;
      if (clear)        part_n = '0;
      else if (part_en) part_n = mem_rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       part_q <= '0;
      else if (part_en) part_q <= part_n;
    end

    assign rdata[g*B +: B] = part_q;
  end
endmodule

// File: rtl/width_bridge.sv
module width_bridge #(
  parameter int AW = 16,
  parameter int W  = 16,
  parameter int B  = 8,
  localparam int BEATS = W / B,
  localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_big_endian,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [W-1:0]  req_wdata,
  output logic [W-1:0]  rdata,
  output logic          done,
  output logic          mem_req,
  output logic          mem_write,
  output logic [AW-1:0] mem_addr,
  output logic [B-1:0]  mem_wdata,
  input  logic          mem_ack,
  input  logic [B-1:0]  mem_rdata
);
  logic          rst_n_int;
  logic          accept, ack_beat;
  logic [CW-1:0] beat, lane;
  logic          write_q, full_q, big_q;
  logic [AW-1:0] addr_q;
  logic [W-1:0]  wdata_q;

  wb_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  wb_sequencer #(.BEATS(BEATS)) u_seq (
    .clk(clk), .rst_n(rst_n_int), .req_valid(req_valid), .full_q(full_q),
    .mem_ack(mem_ack), .accept(accept), .ack_beat(ack_beat), .beat(beat),
    .mem_req(mem_req), .done(done)
  );

  wb_request_reg #(.AW(AW), .W(W)) u_reqr (
    .clk(clk), .rst_n(rst_n_int), .load_en(accept), .req_write(req_write),
    .req_size(req_size), .cfg_big_endian(cfg_big_endian), .req_addr(req_addr),
    .req_wdata(req_wdata), .write_q(write_q), .full_q(full_q), .big_q(big_q),
    .addr_q(addr_q), .wdata_q(wdata_q)
  );

  wb_lane_mux #(.AW(AW), .W(W), .B(B)) u_mux (
    .beat(beat), .full_q(full_q), .big_q(big_q), .addr_q(addr_q),
    .wdata_q(wdata_q), .lane(lane), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  wb_read_assembler #(.W(W), .B(B)) u_asm (
    .clk(clk), .rst_n(rst_n_int), .clear(accept),
    .capture(ack_beat && !write_q), .lane(lane), .mem_rdata(mem_rdata),
    .rdata(rdata)
  );

  assign mem_write = write_q;
endmodule

// File: rtl/wb_checker.sv
module wb_checker #(
  parameter int AW = 16,
  parameter int W  = 16,
  parameter int B  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          mem_req,
  input logic          mem_ack,
  input logic          mem_write,
  input logic [AW-1:0] mem_addr,
  input logic [B-1:0]  mem_wdata,
  input logic [W-1:0]  rdata
);
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_write))); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (!mem_req || (mem_addr == AW'($past(mem_addr) + AW'(1))))); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R8

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(rdata)); // R7

  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_req); // R9
endmodule

bind width_bridge wb_checker #(.AW(AW), .W(W), .B(B)) i_wb_checker (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_write(mem_write), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rdata(rdata)
);

// File: tb/test_width_bridge.sv
module test_width_bridge;
  localparam int AW = 16;
  localparam int W  = 16;
  localparam int B  = 8;

  logic          clk, rst_n;
  logic          cfg_big_endian, req_valid, req_write, req_size;
  logic [AW-1:0] req_addr;
  logic [W-1:0]  req_wdata;
  logic [W-1:0]  rdata;
  logic          done, mem_req, mem_write, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [B-1:0]  mem_wdata, mem_rdata;

  int tests = 0;
  int fails = 0;

  logic [7:0] model  [256];
  logic [7:0] shadow [256];

  int          beat_cnt;
  logic [15:0] first_addr, prev_addr;
  logic        seq_err;

  width_bridge #(.AW(AW), .W(W), .B(B)) i_width_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rdata(rdata), .done(done),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: acknowledges each beat after a random wait
  initial begin
    int wait_cnt;
    wait_cnt  = 0;
    mem_ack   = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_cnt == 0) begin
          mem_ack = 1'b1;
          if (mem_write) model[mem_addr[7:0]] = mem_wdata;
          else           mem_rdata = model[mem_addr[7:0]];
          wait_cnt = int'($urandom % 4);
        end else wait_cnt--;
      end
    end
  end

  // Beat observer
  always @(posedge clk) begin
    if (mem_req && mem_ack) begin
      if (beat_cnt == 0) first_addr <= mem_addr;
      else if (mem_addr != prev_addr + 16'd1) seq_err <= 1'b1;
      prev_addr <= mem_addr;
      beat_cnt  <= beat_cnt + 1;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic logic [15:0] exp_read(input bit full, input bit big, input logic [15:0] a);
    if (!full)    return {8'h00, shadow[a[7:0]]};
    else if (big) return {shadow[a[7:0]], shadow[a[7:0] + 8'd1]};
    else          return {shadow[a[7:0] + 8'd1], shadow[a[7:0]]};
  endfunction

  task automatic apply_write(input bit full, input bit big, input logic [15:0] a, input logic [15:0] d);
    if (!full) shadow[a[7:0]] = d[7:0];
    else if (big) begin
      shadow[a[7:0]] = d[15:8]; shadow[a[7:0] + 8'd1] = d[7:0];
    end else begin
      shadow[a[7:0]] = d[7:0];  shadow[a[7:0] + 8'd1] = d[15:8];
    end
  endtask

  // One access; inject=1 drives disturbing strobes and attribute changes mid-transfer
  task automatic run_txn(input bit wr, input bit full, input bit big,
                         input logic [15:0] a, input logic [15:0] d, input bit inject);
    logic [15:0] held;
    int cyc;
    @(negedge clk);
    beat_cnt = 0; seq_err = 1'b0;
    req_valid = 1'b1; req_write = wr; req_size = full; cfg_big_endian = big;
    req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    if (inject) begin
      req_valid = 1'b1; req_write = 1'b1; req_size = ~full; cfg_big_endian = ~big;
      req_addr = 16'd250; req_wdata = 16'h5A5A;
    end
    cyc = 0;
    while (!done && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
    check(done === 1'b1, "R8 done reached", int'(done), 1);
    check(beat_cnt == (full ? 2 : 1), full ? "R3 word beat count" : "R6 byte beat count", beat_cnt, full ? 2 : 1);
    check(first_addr == a && !seq_err, "R3 beat addresses", int'(first_addr), int'(a));
    if (wr) begin
      apply_write(full, big, a, d);
      check(model[a[7:0]] == shadow[a[7:0]], big ? "R5 store byte0" : "R4 store byte0",
            int'(model[a[7:0]]), int'(shadow[a[7:0]]));
      check(model[a[7:0] + 8'd1] == shadow[a[7:0] + 8'd1], full ? "R4 R5 store byte1" : "R6 neighbour untouched",
            int'(model[a[7:0] + 8'd1]), int'(shadow[a[7:0] + 8'd1]));
    end else begin
      check(rdata == exp_read(full, big, a), full ? "R7 word load" : "R6 byte load",
            int'(rdata), int'(exp_read(full, big, a)));
    end
    held = rdata;
    @(negedge clk);
    check(done === 1'b0, "R8 done single cycle", int'(done), 0);
    req_valid = 1'b0;
    if (inject) begin
      check(model[250] == shadow[250], "R9 busy strobe ignored", int'(model[250]), int'(shadow[250]));
      check(beat_cnt == (full ? 2 : 1), "R10 attributes sampled", beat_cnt, full ? 2 : 1);
    end
    @(negedge clk);
    check(rdata == held && !mem_req, "R7 rdata held while idle", int'(rdata), int'(held));
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) begin
      model[i]  = 8'($urandom);
      shadow[i] = model[i];
    end
    rst_n = 1'b0; cfg_big_endian = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_size = 1'b0; req_addr = '0; req_wdata = '0;
    beat_cnt = 0; seq_err = 1'b0; first_addr = '0; prev_addr = '0;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && mem_req === 1'b0 && rdata === '0, "R1 reset state", int'(rdata), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done === 1'b0 && mem_req === 1'b0 && rdata === '0, "R1 after release", int'({done, mem_req}), 0);

    // Directed byte-order cases
    run_txn(1'b1, 1'b1, 1'b0, 16'd0, 16'hABCD, 1'b0);
    check(model[0] == 8'hCD && model[1] == 8'hAB, "R4 little-endian 0xABCD", int'({model[1], model[0]}), 16'hABCD);
    run_txn(1'b1, 1'b1, 1'b1, 16'd2, 16'hABCD, 1'b0);
    check(model[2] == 8'hAB && model[3] == 8'hCD, "R5 big-endian 0xABCD", int'({model[2], model[3]}), 16'hABCD);
    run_txn(1'b0, 1'b1, 1'b1, 16'd0, 16'h0, 1'b0);
    check(rdata == 16'hCDAB, "R5 cross-order load", int'(rdata), 16'hCDAB);
    run_txn(1'b0, 1'b1, 1'b0, 16'd2, 16'h0, 1'b0);
    check(rdata == 16'hCDAB, "R4 cross-order load", int'(rdata), 16'hCDAB);
    // Byte accesses in both orders
    run_txn(1'b1, 1'b0, 1'b1, 16'd10, 16'h7733, 1'b0);
    run_txn(1'b0, 1'b0, 1'b1, 16'd10, 16'h0, 1'b0);
    run_txn(1'b0, 1'b0, 1'b0, 16'd1, 16'h0, 1'b0);
    // Disturbance during a transfer
    run_txn(1'b1, 1'b1, 1'b0, 16'd20, 16'h1357, 1'b1);
    run_txn(1'b0, 1'b1, 1'b1, 16'd20, 16'h0, 1'b1);
    run_txn(1'b1, 1'b0, 1'b0, 16'd30, 16'h00EE, 1'b1);

    // Random mix
    for (int n = 0; n < 80; n++) begin
      run_txn(1'($urandom), 1'($urandom), 1'($urandom), 16'($urandom % 240),
              16'($urandom), 1'($urandom % 5 == 0));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule